// File: doc/BRIEF.md
# PCI Host Outbound Window Translator

This block sits between a local bus and the request side of a PCI host. A local read or write whose address falls in the 1 GB window starting at 0x8000_0000 becomes one PCI request descriptor carrying an address, a command code, byte enables and write data. The block then waits for the matching PCI response, which may carry read data or an abort, and returns one local response. Only one request is in flight at a time, and the local port reports through a ready flag when it can take the next one.

A control register chooses how the window is used. In memory mode the PCI address keeps the low 30 bits of the local address, and the top two bits come from the control register. In configuration mode the local offset is decoded into a type-0 configuration address. The device field becomes a one-hot IDSEL bit, and the function and dword register fields are carried over. Configuration offsets that would form an address outside the supported range are refused without any bus cycle. A sticky status bit records PCI aborts until software clears it. The control register also sets the drive mode of the PCI reset pin.

Top module: `pci_outbound_xlate`

## Requirements
- R1: A local request with address bits 31:30 equal to 2'b10 (0x8000_0000 to 0xBFFF_FFFF) starts a PCI request. Any other address starts none and is answered on the next clock with the error flag set and read data 0xFFFF_FFFF for a read, or 0 for a write.
- R2: In memory mode (control bit 1 = 0) the PCI address is {control bits 3:2, local address bits 29:0}. The command is 4'h6 for a read and 4'h7 for a write.
- R3: In configuration mode (control bit 1 = 1) the command is 4'hA for a read and 4'hB for a write. The mode is sampled when the request is accepted.
- R4: In configuration mode the local offset holds the device d in bits 15:11, the function in bits 10:8 and the dword register number in bits 7:2. The PCI address is (1 << (13+d)) | function<<8 | register<<2, and address bits 1:0 are 0.
- R5: A configuration request is refused in the same way as R1 if local bits 29:16 are not all zero, if d > 18, or if 13+d >= 20, meaning the formed address would reach 1 MB. With the default parameters this accepts d = 0 to 6 only.
- R6: Status register bit 26 is set when a PCI response arrives with the abort flag. Writing a 1 to bit 26 clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins. All other status bits read 0.
- R7: Control bits 5:4 set the reset pin: 0 gives oe=0, 1 gives oe=1 and out=0, 2 gives oe=1 and out=1, and 3 behaves like 0.
- R8: A completed read returns the PCI read data with the error flag clear. A read that ends in an abort returns 0xFFFF_FFFF with the error flag set. A write returns 0, with the error flag equal to the abort flag.
- R9: Byte enables (bit i = byte lane i) depend on the size code. Size 0 (1 byte) gives 1<<addr[1:0]. Size 1 (2 bytes) gives 4'b0011 or 4'b1100, chosen by addr[1]. Size 2 or 3 gives 4'b1111.
- R10: The PCI request valid is high for exactly one cycle, on the clock after acceptance. The local ready flag stays low from acceptance until the response clock. Requests raised while ready is low are ignored.
- R11: Register index 0 reads back the control word with only bits 5:1 kept. Index 1 reads back the status word. Read data is registered, appearing one clock after the index is presented. Both registers reset to 0.
- R12: The local response is a one-cycle pulse on the clock after the PCI response is sampled. Write data passes unchanged to the PCI request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_req | input | 1 | Local request strobe |
| lb_we | input | 1 | Local request is a write |
| lb_addr | input | 32 | Local byte address |
| lb_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| lb_wdata | input | 32 | Local write data, lane aligned |
| lb_ready | output | 1 | Block can accept a request |
| lb_rsp_valid | output | 1 | Local response pulse |
| lb_rsp_rdata | output | 32 | Local response read data |
| lb_rsp_err | output | 1 | Response ended in abort or refusal |
| rg_we | input | 1 | Register write strobe |
| rg_addr | input | 2 | Register index (0 control, 1 status) |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Registered register read data |
| pq_valid | output | 1 | PCI request valid pulse |
| pq_addr | output | 32 | PCI address |
| pq_cmd | output | 4 | PCI command code |
| pq_be | output | 4 | Byte enables, active high |
| pq_wdata | output | 32 | PCI write data |
| pr_valid | input | 1 | PCI response valid |
| pr_rdata | input | 32 | PCI response read data |
| pr_abort | input | 1 | PCI response is an abort |
| rst_pin_oe | output | 1 | Reset pin output enable |
| rst_pin_out | output | 1 | Reset pin driven level |

## Verification
The bench drives configuration offsets across the device range. The boundary at device 6/7, where the 1 MB limit begins to apply, catches a design that checks only the device > 18 limit, because that design would emit an IDSEL bit at 20 or above. Aborted reads must return all ones and leave the sticky status bit set until a write of 1 clears it; an inverted clear sense or a missing set shows up on readback. Stray requests made while a request is outstanding are checked to cause no second PCI request, which exposes a design that accepts while busy. Sub-word byte enables and the two programmable upper address bits are compared on every random memory access.

// File: rtl/pcio_pkg.sv
package pcio_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [3:0] {
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } pci_cmd_e;

  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [1:0] size);
    logic [3:0] m;
    case (size)
      2'd0:    m = 4'b0001 << lo;
      2'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pcio_regs.sv
module pcio_regs #(
  parameter int RG_AW     = 2,
  parameter int ABORT_BIT = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rg_we,
  input  logic [RG_AW-1:0]  rg_addr,
  input  logic [31:0]       rg_wdata,
  output logic [31:0]       rg_rdata,
  input  logic              abort_set,
  output logic              cfg_sel,
  output logic [1:0]        hi_bits,
  output logic [1:0]        rst_mode,
  output logic              abort_flag
);
  localparam logic [RG_AW-1:0] IDX_CTRL = RG_AW'(0);
  localparam logic [RG_AW-1:0] IDX_STAT = RG_AW'(1);

  logic [4:0] ctrl_q;
  logic       abort_q;
  logic       clr_req;

  assign clr_req = rg_we && (rg_addr == IDX_STAT) && rg_wdata[ABORT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      abort_q  <= 1'b0;
      rg_rdata <= '0;
    end else begin
      if (rg_we && rg_addr == IDX_CTRL) ctrl_q <= rg_wdata[5:1];
      if (abort_set)    abort_q <= 1'b1;
      else if (clr_req) abort_q <= 1'b0;
      case (rg_addr)
        IDX_CTRL: rg_rdata <= {26'd0, ctrl_q, 1'b0};
        IDX_STAT: rg_rdata <= 32'(abort_q) << ABORT_BIT;
        default:  rg_rdata <= '0;
      endcase
    end
  end

  assign cfg_sel    = ctrl_q[0];
  assign hi_bits    = ctrl_q[2:1];
  assign rst_mode   = ctrl_q[4:3];
  assign abort_flag = abort_q;

  p_abort_sets_r6: assert property (@(posedge clk) disable iff (rst)
    abort_set |=> abort_q);
  p_abort_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (abort_q && !clr_req) |=> abort_q);
endmodule

// File: rtl/pcio_xlate.sv
module pcio_xlate
  import pcio_pkg::*;
#(
  parameter logic [1:0] WIN_TAG       = 2'b10,
  parameter int         IDSEL_BASE    = 13,
  parameter int         DEV_MAX       = 18,
  parameter int         CFG_SPAN_LOG2 = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  input  logic              cfg_sel,
  input  logic [1:0]        hi_bits,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [3:0]        cmd,
  output logic [BE_W-1:0]   be,
  output logic              reject
);
  logic [4:0]        dev;
  logic [ADDR_W-1:0] idsel;
  logic              win_hit;
  logic              cfg_bad;

  assign dev = addr[15:11];

  for (genvar g = 0; g < ADDR_W; g++) begin : g_idsel
    if (g >= IDSEL_BASE && (g - IDSEL_BASE) < 32) begin : g_on
      assign idsel[g] = (dev == 5'(g - IDSEL_BASE));
    end else begin : g_off
      assign idsel[g] = 1'b0;
    end
  end

  assign win_hit = (addr[31:30] == WIN_TAG);
  assign cfg_bad = (|addr[29:16]) || (int'(dev) > DEV_MAX) ||
                   ((IDSEL_BASE + int'(dev)) >= CFG_SPAN_LOG2);

  always_comb begin
    if (cfg_sel) begin
      pci_addr = idsel | {21'd0, addr[10:2], 2'b00};
      cmd      = we ? CMD_CFG_WR : CMD_CFG_RD;
    end else begin
      pci_addr = {hi_bits, addr[29:0]};
      cmd      = we ? CMD_MEM_WR : CMD_MEM_RD;
    end
    be     = lane_mask(addr[1:0], size);
    reject = !win_hit || (cfg_sel && cfg_bad);
  end
endmodule

// File: rtl/pcio_seq.sv
module pcio_seq
  import pcio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_req,
  input  logic              lb_we,
  input  logic [DATA_W-1:0] lb_wdata,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [3:0]        x_cmd,
  input  logic [BE_W-1:0]   x_be,
  input  logic              x_reject,
  output logic              lb_ready,
  output logic              lb_rsp_valid,
  output logic [DATA_W-1:0] lb_rsp_rdata,
  output logic              lb_rsp_err,
  output logic              pq_valid,
  output logic [ADDR_W-1:0] pq_addr,
  output logic [3:0]        pq_cmd,
  output logic [BE_W-1:0]   pq_be,
  output logic [DATA_W-1:0] pq_wdata,
  input  logic              pr_valid,
  input  logic [DATA_W-1:0] pr_rdata,
  input  logic              pr_abort,
  output logic              abort_set
);
  logic busy_q;
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      we_q         <= 1'b0;
      pq_valid     <= 1'b0;
      pq_addr      <= '0;
      pq_cmd       <= '0;
      pq_be        <= '0;
      pq_wdata     <= '0;
      lb_rsp_valid <= 1'b0;
      lb_rsp_rdata <= '0;
      lb_rsp_err   <= 1'b0;
    end else begin
      pq_valid     <= 1'b0;
      lb_rsp_valid <= 1'b0;
      if (!busy_q) begin
        if (lb_req) begin
          if (x_reject) begin
            lb_rsp_valid <= 1'b1;
            lb_rsp_err   <= 1'b1;
            lb_rsp_rdata <= lb_we ? '0 : '1;
          end else begin
            busy_q   <= 1'b1;
            we_q     <= lb_we;
            pq_valid <= 1'b1;
            pq_addr  <= x_addr;
            pq_cmd   <= x_cmd;
            pq_be    <= x_be;
            pq_wdata <= lb_wdata;
          end
        end
      end else if (pr_valid) begin
        busy_q       <= 1'b0;
        lb_rsp_valid <= 1'b1;
        lb_rsp_err   <= pr_abort;
        lb_rsp_rdata <= we_q ? '0 : (pr_abort ? '1 : pr_rdata);
      end
    end
  end

  assign lb_ready  = !busy_q;
  assign abort_set = busy_q && pr_valid && pr_abort;

  p_single_issue_r10: assert property (@(posedge clk) disable iff (rst)
    pq_valid |=> !pq_valid);
  p_no_issue_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !pq_valid);
  p_abort_read_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && pr_valid && pr_abort && !we_q) |=> (lb_rsp_valid && lb_rsp_err && lb_rsp_rdata == '1));
  p_be_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    pq_valid |-> (pq_be != '0));
endmodule

// File: rtl/pci_outbound_xlate.sv
module pci_outbound_xlate
  import pcio_pkg::*;
#(
  parameter int RG_AW     = 2,
  parameter int ABORT_BIT = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_req,
  input  logic              lb_we,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [1:0]        lb_size,
  input  logic [DATA_W-1:0] lb_wdata,
  output logic              lb_ready,
  output logic              lb_rsp_valid,
  output logic [DATA_W-1:0] lb_rsp_rdata,
  output logic              lb_rsp_err,
  input  logic              rg_we,
  input  logic [RG_AW-1:0]  rg_addr,
  input  logic [31:0]       rg_wdata,
  output logic [31:0]       rg_rdata,
  output logic              pq_valid,
  output logic [ADDR_W-1:0] pq_addr,
  output logic [3:0]        pq_cmd,
  output logic [BE_W-1:0]   pq_be,
  output logic [DATA_W-1:0] pq_wdata,
  input  logic              pr_valid,
  input  logic [DATA_W-1:0] pr_rdata,
  input  logic              pr_abort,
  output logic              rst_pin_oe,
  output logic              rst_pin_out
);
  logic              cfg_sel;
  logic [1:0]        hi_bits;
  logic [1:0]        rst_mode;
  logic              abort_flag;
  logic              abort_set;
  logic [ADDR_W-1:0] x_addr;
  logic [3:0]        x_cmd;
  logic [BE_W-1:0]   x_be;
  logic              x_reject;

  pcio_regs #(.RG_AW(RG_AW), .ABORT_BIT(ABORT_BIT)) u_regs (
    .clk(clk), .rst(rst), .rg_we(rg_we), .rg_addr(rg_addr), .rg_wdata(rg_wdata),
    .rg_rdata(rg_rdata), .abort_set(abort_set), .cfg_sel(cfg_sel),
    .hi_bits(hi_bits), .rst_mode(rst_mode), .abort_flag(abort_flag)
  );

  pcio_xlate u_xlate (
    .addr(lb_addr), .size(lb_size), .we(lb_we), .cfg_sel(cfg_sel),
    .hi_bits(hi_bits), .pci_addr(x_addr), .cmd(x_cmd), .be(x_be), .reject(x_reject)
  );

  pcio_seq u_seq (
    .clk(clk), .rst(rst), .lb_req(lb_req), .lb_we(lb_we), .lb_wdata(lb_wdata),
    .x_addr(x_addr), .x_cmd(x_cmd), .x_be(x_be), .x_reject(x_reject),
    .lb_ready(lb_ready), .lb_rsp_valid(lb_rsp_valid), .lb_rsp_rdata(lb_rsp_rdata),
    .lb_rsp_err(lb_rsp_err), .pq_valid(pq_valid), .pq_addr(pq_addr), .pq_cmd(pq_cmd),
    .pq_be(pq_be), .pq_wdata(pq_wdata), .pr_valid(pr_valid), .pr_rdata(pr_rdata),
    .pr_abort(pr_abort), .abort_set(abort_set)
  );

  assign rst_pin_oe  = (rst_mode == 2'd1) || (rst_mode == 2'd2);
  assign rst_pin_out = (rst_mode == 2'd2);

  p_cfg_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    (pq_valid && (pq_cmd == CMD_CFG_RD || pq_cmd == CMD_CFG_WR)) |->
      ($countones(pq_addr[31:13]) == 1 && pq_addr[31:20] == '0 && pq_addr[1:0] == 2'b00));
  p_abort_visible_r6: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && pr_abort && !lb_ready) |=> abort_flag);
endmodule

// File: tb/test_pci_outbound_xlate.sv
module test_pci_outbound_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        lb_req, lb_we;
  logic [31:0] lb_addr, lb_wdata;
  logic [1:0]  lb_size;
  logic        lb_ready, lb_rsp_valid, lb_rsp_err;
  logic [31:0] lb_rsp_rdata;
  logic        rg_we;
  logic [1:0]  rg_addr;
  logic [31:0] rg_wdata, rg_rdata;
  logic        pq_valid;
  logic [31:0] pq_addr, pq_wdata;
  logic [3:0]  pq_cmd, pq_be;
  logic        pr_valid, pr_abort;
  logic [31:0] pr_rdata;
  logic        rst_pin_oe, rst_pin_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic       m_cfg;
  logic [1:0] m_hi;
  logic       m_abort;

  always #5 clk = ~clk;

  pci_outbound_xlate i_pci_outbound_xlate (
    .clk(clk), .rst(rst), .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr),
    .lb_size(lb_size), .lb_wdata(lb_wdata), .lb_ready(lb_ready),
    .lb_rsp_valid(lb_rsp_valid), .lb_rsp_rdata(lb_rsp_rdata), .lb_rsp_err(lb_rsp_err),
    .rg_we(rg_we), .rg_addr(rg_addr), .rg_wdata(rg_wdata), .rg_rdata(rg_rdata),
    .pq_valid(pq_valid), .pq_addr(pq_addr), .pq_cmd(pq_cmd), .pq_be(pq_be),
    .pq_wdata(pq_wdata), .pr_valid(pr_valid), .pr_rdata(pr_rdata), .pr_abort(pr_abort),
    .rst_pin_oe(rst_pin_oe), .rst_pin_out(rst_pin_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_reject(input logic [31:0] a, input logic cfg);
    int d;
    d = int'(a[15:11]);
    if (a[31:30] != 2'b10) return 1'b1;
    if (cfg && ((a[29:16] != 0) || d > 18 || 13 + d >= 20)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [31:0] a, input logic cfg, input logic [1:0] hi);
    if (cfg) return (32'd1 << (13 + int'(a[15:11]))) | {21'd0, a[10:8], a[7:2], 2'b00};
    return {hi, a[29:0]};
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] lo, input logic [1:0] sz);
    if (sz == 2'd0) return (lo == 0) ? 4'h1 : (lo == 1) ? 4'h2 : (lo == 2) ? 4'h4 : 4'h8;
    if (sz == 2'd1) return lo[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [3:0] exp_cmd(input logic we, input logic cfg);
    if (cfg) return we ? 4'hB : 4'hA;
    return we ? 4'h7 : 4'h6;
  endfunction

  task automatic reg_wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    rg_we = 1'b1; rg_addr = idx; rg_wdata = d;
    @(negedge clk);
    rg_we = 1'b0;
    if (idx == 2'd0) begin m_cfg = d[1]; m_hi = d[3:2]; end
    if (idx == 2'd1 && d[26]) m_abort = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    rg_addr = idx;
    @(negedge clk);
    d = rg_rdata;
  endtask

  task automatic access(input string tag, input logic we, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] wd, input logic ab,
                        input logic [31:0] td, input int waitn, input logic stray);
    logic rej;
    rej = exp_reject(a, m_cfg);
    @(negedge clk);
    lb_req = 1'b1; lb_we = we; lb_addr = a; lb_size = sz; lb_wdata = wd;
    @(negedge clk);
    lb_req = 1'b0;
    if (rej) begin
      chk({tag, " reject rsp_valid"}, 32'(lb_rsp_valid), 32'd1);
      chk({tag, " reject err"}, 32'(lb_rsp_err), 32'd1);
      chk({tag, " reject rdata"}, lb_rsp_rdata, we ? 32'd0 : 32'hFFFF_FFFF);
      chk({tag, " reject no bus cycle"}, 32'(pq_valid), 32'd0);
      return;
    end
    chk({tag, " pq_valid"}, 32'(pq_valid), 32'd1);
    chk({tag, " pq_addr"}, pq_addr, exp_paddr(a, m_cfg, m_hi));
    chk({tag, " pq_cmd"}, 32'(pq_cmd), 32'(exp_cmd(we, m_cfg)));
    chk({tag, " R9 pq_be"}, 32'(pq_be), 32'(exp_be(a[1:0], sz)));
    if (we) chk({tag, " R12 pq_wdata"}, pq_wdata, wd);
    chk({tag, " R10 ready low"}, 32'(lb_ready), 32'd0);
    for (int i = 0; i < waitn; i++) begin
      if (stray) begin lb_req = 1'b1; lb_addr = 32'h8000_0000; end
      @(negedge clk);
      lb_req = 1'b0;
      chk({tag, " R10 no reissue"}, 32'(pq_valid), 32'd0);
      chk({tag, " R12 no early rsp"}, 32'(lb_rsp_valid), 32'd0);
    end
    pr_valid = 1'b1; pr_abort = ab; pr_rdata = td;
    @(negedge clk);
    pr_valid = 1'b0; pr_abort = 1'b0;
    chk({tag, " R12 rsp_valid"}, 32'(lb_rsp_valid), 32'd1);
    chk({tag, " R8 rsp_err"}, 32'(lb_rsp_err), 32'(ab));
    chk({tag, " R8 rsp_rdata"}, lb_rsp_rdata, we ? 32'd0 : (ab ? 32'hFFFF_FFFF : td));
    chk({tag, " R10 ready back"}, 32'(lb_ready), 32'd1);
    if (ab) m_abort = 1'b1;
    @(negedge clk);
    chk({tag, " R12 rsp pulse"}, 32'(lb_rsp_valid), 32'd0);
    chk({tag, " R10 stray ignored"}, 32'(pq_valid), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    rst = 1'b1; lb_req = 0; lb_we = 0; lb_addr = 0; lb_size = 0; lb_wdata = 0;
    rg_we = 0; rg_addr = 0; rg_wdata = 0; pr_valid = 0; pr_abort = 0; pr_rdata = 0;
    m_cfg = 0; m_hi = 0; m_abort = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 reset ready", 32'(lb_ready), 32'd1);
    chk("R11 reset pq_valid", 32'(pq_valid), 32'd0);
    chk("R7 reset pin oe", 32'(rst_pin_oe), 32'd0);
    reg_rd(2'd0, rd); chk("R11 reset ctrl", rd, 32'd0);
    reg_rd(2'd1, rd); chk("R11 reset status", rd, 32'd0);

    // R11 readback masks
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, rd); chk("R11 ctrl readback", rd, 32'h0000_003E);
    reg_wr(2'd0, 32'h0);

    // R7 reset pin modes
    for (int md = 0; md < 4; md++) begin
      reg_wr(2'd0, 32'(md) << 4);
      chk("R7 pin oe", 32'(rst_pin_oe), 32'((md == 1) || (md == 2)));
      chk("R7 pin out", 32'(rst_pin_out), 32'(md == 2));
    end
    reg_wr(2'd0, 32'h0);

    // R1 window edges
    access("R1 below window", 1'b0, 32'h7FFF_FFFC, 2'd2, 0, 0, 0, 0, 0);
    access("R1 above window", 1'b1, 32'hC000_0000, 2'd2, 32'h1234, 0, 0, 0, 0);
    access("R1 low edge", 1'b0, 32'h8000_0000, 2'd2, 0, 0, 32'hCAFE_0001, 1, 0);
    access("R1 high edge", 1'b0, 32'hBFFF_FFFF, 2'd0, 0, 0, 32'h55AA_55AA, 0, 0);

    // R2 upper bits
    reg_wr(2'd0, 32'h0000_000C);
    access("R2 hi bits 3", 1'b1, 32'h9234_5678, 2'd1, 32'hDEAD_BEEF, 0, 0, 2, 1);
    reg_wr(2'd0, 32'h0000_0004);
    access("R2 hi bits 1", 1'b0, 32'hA000_0013, 2'd0, 0, 0, 32'h0102_0304, 0, 0);

    // R3/R4/R5 configuration mode
    reg_wr(2'd0, 32'h0000_0002);
    access("R4 dev0", 1'b0, 32'h8000_0004, 2'd2, 0, 0, 32'h1111_2222, 0, 0);
    access("R4 dev3 fn5", 1'b1, 32'h8000_1D3C, 2'd2, 32'h8000_0000, 0, 0, 1, 0);
    access("R5 dev6 last ok", 1'b0, 32'h8000_3000 | 32'h0700, 2'd2, 0, 0, 32'h3, 0, 0);
    access("R5 dev7 over 1MB", 1'b0, 32'h8000_3800, 2'd2, 0, 0, 0, 0, 0);
    access("R5 dev19", 1'b0, 32'h8000_9800, 2'd2, 0, 0, 0, 0, 0);
    access("R5 upper offset", 1'b1, 32'h8010_0000, 2'd2, 0, 0, 0, 0, 0);
    access("R3 cfg outside window", 1'b0, 32'h4000_0000, 2'd2, 0, 0, 0, 0, 0);

    // R8/R6 aborted read then status handling
    access("R8 abort read", 1'b0, 32'h8000_1000, 2'd2, 0, 1, 32'h1234_5678, 1, 0);
    reg_rd(2'd1, rd); chk("R6 status after abort", rd, 32'h0400_0000);
    reg_wr(2'd1, 32'hFBFF_FFFF);
    reg_rd(2'd1, rd); chk("R6 write 0 keeps", rd, 32'h0400_0000);
    reg_wr(2'd1, 32'h0400_0000);
    reg_rd(2'd1, rd); chk("R6 write 1 clears", rd, 32'h0);
    access("R8 abort write", 1'b1, 32'h8000_0800, 2'd2, 32'h9, 1, 0, 0, 0);
    reg_rd(2'd1, rd); chk("R6 status after write abort", rd, 32'h0400_0000);
    reg_wr(2'd1, 32'h0400_0000);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [31:0] r;
      if ((n % 25) == 0) reg_wr(2'd0, $urandom & 32'h0000_000E);
      r = $urandom;
      if (m_cfg) begin
        a = {2'b10, (r[3:0] == 0) ? 14'(r[17:4]) : 14'd0, 5'($urandom_range(0, 9)), r[26:24], r[23:18], r[29:28]};
      end else begin
        a = $urandom;
        if (r[3:0] != 0) a[31:30] = 2'b10;
      end
      access(m_cfg ? "R4 R5 random cfg" : "R2 R9 random mem", r[30], a, 2'(r[9:8]),
             $urandom, (r[15:12] == 0), $urandom, int'(r[21:20]), r[22]);
      if (m_abort) begin
        reg_rd(2'd1, rd); chk("R6 random abort status", rd, 32'h0400_0000);
        reg_wr(2'd1, 32'h0400_0000);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule